// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level page table held in memory. A root register holds the base of the top-level table. Software changes only this register when it switches address spaces. The top 10 address bits select a word in the top-level table. That word names the base of a leaf table. The next 10 bits select a word in the leaf table, and that word supplies the physical page number and the access rights. The low 12 bits are the offset inside a 4 KB page and are copied through unchanged.

A requester presents one virtual address and an access type (read or write). The walker then issues at most two word reads on a memory port that allows one read in flight at a time. It finishes with a single-cycle response that carries either the physical address or a fault code. Every table entry uses the same layout:
- bit 0 = present
- bit 1 = readable
- bit 2 = writable
- bits 31:12 = page number

A table occupies one 4 KB page: 1024 entries of 4 bytes each.

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready is 1, and busy, mem_req_valid and rsp_valid are 0.
- R2: The first read goes to {root[31:12], 12'b0} + va[31:22]*4. The second read goes to {top_entry[31:12], 12'b0} + va[21:12]*4. The second read is issued only after the first response arrives.
- R3: A top-level entry with bit 0 clear ends the walk with fault code 1, after exactly one memory read.
- R4: A leaf entry with bit 0 clear ends the walk with fault code 2. This takes precedence over any rights bits.
- R5: A read needs leaf bit 1 and a write needs leaf bit 2. If the bit is missing and the leaf is present, the fault code is 3.
- R6: A translation that succeeds gives rsp_paddr = {leaf[31:12], va[11:0]} with fault code 0.
- R7: rsp_valid is high for exactly one cycle per accepted request, and req_ready is high again in the next cycle. busy is high from the cycle after acceptance through the response cycle.
- R8: A request is accepted only while req_ready is 1. A req_valid raised while busy is ignored: it starts no walk and causes no memory read.
- R9: Once mem_req_valid is raised, it and mem_req_addr stay unchanged until mem_req_ready is seen high.
- R10: A root write in the same cycle as request acceptance is used by that request. A root write during a walk does not change that walk but applies to the next one.
- R11: rsp_fault is 1 exactly when the fault code is non-zero, and rsp_paddr is 0 on a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_we | input | 1 | Write enable for the root register |
| root_wdata | input | 32 | New root table base |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access type: 1 = write, 0 = read |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Entry word |
| rsp_valid | output | 1 | Translation result, one cycle |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Translation failed |
| rsp_fault_code | output | 2 | 0 ok, 1 top absent, 2 leaf absent, 3 rights |

## Verification
A root register write can land in the same cycle as request acceptance. It can also land while a walk is in flight. The bench drives root_we together with req_valid in one cycle, and separately in the middle of a slow walk. The behavioural model predicts which root each walk must use, and the bench checks both the first read address and the final physical address against that prediction. Requests raised while busy and a stalled memory handshake are also mixed in. Busy and response timing are compared against the model on every clock.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int IDX_W = 10,
  parameter int OFF_W = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        root_we,
  input  logic [31:0] root_wdata,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_vaddr,
  input  logic        req_write,
  output logic        busy,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  output logic        rsp_valid,
  output logic [31:0] rsp_paddr,
  output logic        rsp_fault,
  output logic [1:0]  rsp_fault_code
);
  localparam int PN_W  = 32 - OFF_W;
  localparam int HI_LO = 32 - IDX_W;
  localparam int MD_LO = OFF_W;

  typedef enum logic [1:0] {S_IDLE, S_RD1, S_RD2, S_DONE} st_t;

  st_t         st;
  logic        issued, wr_q;
  logic [31:0] root_q, va_q, maddr_q, paddr_q;
  logic [1:0]  code_q;

  logic [31:0] root_eff, top_addr, leaf_addr;
  logic        accept, rsp_hit, perm_ok;

  assign root_eff  = root_we ? root_wdata : root_q;
  assign accept    = req_valid && (st == S_IDLE);
  assign rsp_hit   = issued && mem_rsp_valid;
  assign perm_ok   = wr_q ? mem_rsp_data[2] : mem_rsp_data[1];
  assign top_addr  = {root_eff[31:OFF_W], {OFF_W{1'b0}}}
                   + (32'(req_vaddr[31:HI_LO]) << 2);
  assign leaf_addr = {mem_rsp_data[31:OFF_W], {OFF_W{1'b0}}}
                   + (32'(va_q[HI_LO-1:MD_LO]) << 2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      issued  <= 1'b0;
      wr_q    <= 1'b0;
      root_q  <= '0;
      va_q    <= '0;
      maddr_q <= '0;
      paddr_q <= '0;
      code_q  <= '0;
    end else begin
      if (root_we) root_q <= root_wdata;
      case (st)
        S_IDLE: if (accept) begin
          va_q    <= req_vaddr;
          wr_q    <= req_write;
          maddr_q <= top_addr;
          issued  <= 1'b0;
          st      <= S_RD1;
        end
        S_RD1, S_RD2: begin
          if (mem_req_valid && mem_req_ready) issued <= 1'b1;
          if (rsp_hit) begin
            issued <= 1'b0;
            if (st == S_RD1) begin
              if (!mem_rsp_data[0]) begin
                code_q  <= 2'd1;
                paddr_q <= '0;
                st      <= S_DONE;
              end else begin
                maddr_q <= leaf_addr;
                st      <= S_RD2;
              end
            end else begin
              st <= S_DONE;
              if (!mem_rsp_data[0]) begin
                code_q  <= 2'd2;
                paddr_q <= '0;
              end else if (!perm_ok) begin
                code_q  <= 2'd3;
                paddr_q <= '0;
              end else begin
                code_q  <= 2'd0;
                paddr_q <= {mem_rsp_data[31:OFF_W], va_q[OFF_W-1:0]};
              end
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready      = (st == S_IDLE);
  assign busy           = (st != S_IDLE);
  assign mem_req_valid  = ((st == S_RD1) || (st == S_RD2)) && !issued;
  assign mem_req_addr   = maddr_q;
  assign rsp_valid      = (st == S_DONE);
  assign rsp_paddr      = paddr_q;
  assign rsp_fault_code = code_q;
  assign rsp_fault      = (code_q != 2'd0);

  assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_rsp_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));

  assert_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (busy && !rsp_valid));

  assert_top_absent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RD1 && rsp_hit && !mem_rsp_data[0])
      |=> (rsp_valid && rsp_fault_code == 2'd1 && !mem_req_valid));

  assert_rights_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RD2 && rsp_hit && mem_rsp_data[0] && !perm_ok)
      |=> (rsp_valid && rsp_fault && rsp_fault_code == 2'd3));

  assert_fault_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == 32'd0));
endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic root_we = 1'b0;
  logic [31:0] root_wdata = '0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [31:0] req_vaddr = '0;
  logic req_write = 1'b0;
  logic busy;
  logic mem_req_valid;
  logic mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic rsp_valid;
  logic [31:0] rsp_paddr;
  logic rsp_fault;
  logic [1:0] rsp_fault_code;

  always #10 clk = ~clk;

  pt_walker u_dut (
    .clk(clk), .rst_n(rst_n), .root_we(root_we), .root_wdata(root_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .busy(busy), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .rsp_fault_code(rsp_fault_code)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  logic [31:0] pmem [logic [31:0]];
  logic [31:0] reads [$];
  logic [31:0] model_root = '0;
  bit          armed = 0, pending = 0;
  logic [31:0] exp_pa, exp_a1, exp_a2;
  logic [1:0]  exp_code;
  int          exp_reads;
  int          lat = 0;
  bit          stall_mode = 0, tog = 0;
  bit          prev_v = 0, prev_r = 0;
  logic [31:0] prev_a = '0;
  bit          acc_pend = 0;
  logic [31:0] acc_addr = '0;
  int          dly = 0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return pmem.exists(a) ? pmem[a] : 32'd0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ref_walk(input logic [31:0] root, input logic [31:0] va, input bit wr);
    logic [31:0] e1, e2;
    exp_a1 = {root[31:12], 12'd0} + {20'd0, va[31:22], 2'b00};
    e1 = rd(exp_a1);
    exp_a2 = 32'd0;
    if (!e1[0]) begin
      exp_code = 2'd1; exp_pa = 32'd0; exp_reads = 1;
    end else begin
      exp_a2 = {e1[31:12], 12'd0} + {20'd0, va[21:12], 2'b00};
      e2 = rd(exp_a2);
      exp_reads = 2;
      if (!e2[0])                   begin exp_code = 2'd2; exp_pa = 32'd0; end
      else if (wr ? !e2[2] : !e2[1]) begin exp_code = 2'd3; exp_pa = 32'd0; end
      else                          begin exp_code = 2'd0; exp_pa = {e2[31:12], va[11:0]}; end
    end
  endtask

  // memory responder: one read in flight, programmable latency and stalls
  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    if (rst_n && prev_v && prev_r) begin
      reads.push_back(prev_a);
      acc_pend = 1; acc_addr = prev_a; dly = lat;
    end
    if (rst_n && prev_v && !prev_r) begin
      check("R9 hold valid", {31'd0, mem_req_valid}, 32'd1);
      check("R9 hold addr", mem_req_addr, prev_a);
    end
    if (acc_pend) begin
      if (dly == 0) begin
        mem_rsp_valid = 1'b1; mem_rsp_data = rd(acc_addr); acc_pend = 0;
      end else dly--;
    end
    tog = ~tog;
    mem_req_ready = stall_mode ? tog : 1'b1;
    prev_v = mem_req_valid; prev_r = mem_req_ready; prev_a = mem_req_addr;
  end

  // cycle-by-cycle model comparison
  always @(negedge clk) begin
    if (rst_n) begin
      if (armed) begin pending = 1; armed = 0; end
      check("R7 busy", {31'd0, busy}, {31'd0, pending});
      if (rsp_valid) begin
        check("R7 rsp only when pending", {31'd0, pending}, 32'd1);
        check("R6 paddr", rsp_paddr, exp_pa);
        check("R3/R4/R5 code", {30'd0, rsp_fault_code}, {30'd0, exp_code});
        check("R11 fault flag", {31'd0, rsp_fault}, {31'd0, exp_code != 2'd0});
        check("R2/R3 read count", reads.size(), exp_reads);
        if (reads.size() > 0) check("R2 first addr", reads[0], exp_a1);
        if (reads.size() > 1) check("R2 second addr", reads[1], exp_a2);
        pending = 0;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic wait_idle();
    for (int i = 0; i < 500 && (req_ready !== 1'b1 || pending || armed); i++) @(negedge clk);
  endtask

  task automatic set_root(input logic [31:0] r);
    @(negedge clk); #1;
    root_we = 1'b1; root_wdata = r; model_root = r;
    @(negedge clk); #1;
    root_we = 1'b0;
  endtask

  task automatic start(input logic [31:0] va, input bit wr, input bit rw, input logic [31:0] r);
    wait_idle();
    @(negedge clk); #1;
    if (rw) begin root_we = 1'b1; root_wdata = r; model_root = r; end
    req_valid = 1'b1; req_vaddr = va; req_write = wr;
    ref_walk(model_root, va, wr);
    reads.delete();
    armed = 1;
    @(negedge clk); #1;
    req_valid = 1'b0; root_we = 1'b0;
  endtask

  task automatic xlate(input logic [31:0] va, input bit wr);
    start(va, wr, 0, 0);
    wait_idle();
  endtask

  function automatic logic [31:0] mkva(input int i1, input int i2, input int off);
    return {i1[9:0], i2[9:0], off[11:0]};
  endfunction

  initial begin
    pmem[32'h0001_0004] = 32'h0002_0001;
    pmem[32'h0001_0008] = 32'hFFFF_F006;
    pmem[32'h0002_000C] = 32'hABCD_E003;
    pmem[32'h0002_0010] = 32'h5555_5007;
    pmem[32'h0002_0014] = 32'h7777_7006;
    pmem[32'h0002_0018] = 32'h3333_3005;
    pmem[32'h0003_0004] = 32'h0004_0001;
    pmem[32'h0004_000C] = 32'h1234_5007;

    repeat (3) @(negedge clk);
    check("R1 req_ready", {31'd0, req_ready}, 32'd1);
    check("R1 busy", {31'd0, busy}, 32'd0);
    check("R1 mem_req_valid", {31'd0, mem_req_valid}, 32'd0);
    check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    #1 rst_n = 1'b1;

    set_root(32'h0001_0000);
    xlate(mkva(1, 3, 'h123), 0);   // R6 read allowed
    xlate(mkva(1, 3, 'h123), 1);   // R5 write denied
    xlate(mkva(1, 4, 'hFFF), 1);   // R6 write allowed
    xlate(mkva(1, 5, 'h010), 0);   // R4 leaf absent, rights bits set
    xlate(mkva(2, 7, 'h000), 0);   // R3 top absent, one read
    xlate(mkva(1, 6, 'h456), 1);   // R6 write-only page, write
    xlate(mkva(1, 6, 'h456), 0);   // R5 write-only page, read denied
    xlate(mkva(0, 0, 'h000), 1);   // R3 unmapped top entry

    stall_mode = 1; lat = 3;
    xlate(mkva(1, 3, 'hABC), 0);   // R9 stalled handshake
    xlate(mkva(2, 1, 'h001), 1);   // R3 under stalls
    stall_mode = 0; lat = 0;

    // R10 root write in the cycle of acceptance
    start(mkva(1, 3, 'h777), 0, 1, 32'h0003_0000);
    wait_idle();

    // R10 root write during a walk: old root for this walk, new for the next
    lat = 5;
    start(mkva(1, 3, 'h321), 1, 0, 0);
    set_root(32'h0001_0000);
    wait_idle();
    xlate(mkva(1, 3, 'h321), 0);

    // R8 request held while busy is ignored
    start(mkva(1, 4, 'h00A), 0, 0, 0);
    @(negedge clk); #1;
    req_valid = 1'b1; req_vaddr = mkva(2, 2, 'h0); req_write = 1'b1;
    repeat (4) @(negedge clk);
    #1 req_valid = 1'b0;
    wait_idle();
    repeat (6) @(negedge clk);
    check("R8 no extra reads", reads.size(), 2);
    check("R8 idle after", {31'd0, busy}, 32'd0);
    lat = 0;

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule